// File: doc/BRIEF.md
# Write Cache with Switchable Acknowledge

A small direct-mapped cache sits between a host request port and a slow storage port. Each line holds one data word, a valid flag and a dirty flag. A read that finds its word in the cache is answered on the next cycle, with no storage traffic. A read that misses fetches the word from storage and replaces whatever the line held. After every read miss, the cache also fetches the following address into its own line, in the hope that it will be read next.

Writes always go into the cache first. The `early_ack_en` input is sampled with each write and picks between two behaviours. With early acknowledge, the write is answered as soon as the line holds it, and the line stays dirty until a background drain copies it out. With early acknowledge off, the line is stored clean and the answer waits for the storage write to finish, so the cache acts only as a write buffer. The block exposes a read counter and a hit counter, so the hit ratio can be worked out.

Top module: `wc_cache`

## Requirements
- R1: A read whose address is present (line valid, stored tag equal to `req_addr[7:2]`, line index `req_addr[1:0]` at default parameters) is acknowledged one cycle after it is presented to an idle block. It returns the cached word and starts no storage read.
- R2: A read miss issues a storage read of the requested address, installs the returned word in the indexed line, and acknowledges the host with that word after the storage transaction completes.
- R3: After each read miss has been answered, the block fetches address+1 from storage into its line, unless that line already holds address+1. A later read of address+1 is then a hit.
- R4: The read-ahead never replaces a line that is valid and dirty. Such a fetch is skipped, and the dirty word stays readable as a hit.
- R5: With `early_ack_en`=1, a write to an idle block is acknowledged one cycle after it is presented. At that moment storage still holds the old value.
- R6: With `early_ack_en`=0, a write is acknowledged only after its storage write has completed, so storage holds the new value when the acknowledge is seen.
- R7: When a read miss or a write replaces a valid dirty line of a different address, that line's word is written to storage before the new word is installed.
- R8: While no host request is pending, dirty lines are written to storage in the background. After enough idle time, storage matches every value the host has written.
- R9: `read_cnt` increases by exactly one for every accepted read. `hit_cnt` increases by one for every read hit and never without a read.
- R10: Only one storage transaction is open at a time. `st_valid`, `st_addr` and `st_we` stay unchanged from the start of a transaction until `st_ack`.
- R11: `req_ack` is never high in a cycle in which `st_valid` is high.
- R12: After reset, `req_ack` and `st_valid` are low, both counters are zero, and every line is invalid, so the first read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_ack_en | input | 1 | Write acknowledge mode, sampled with each write: 1 = acknowledge once cached, 0 = acknowledge after storage write |
| req_valid | input | 1 | Host request pending; held until `req_ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| req_ack | output | 1 | One-cycle acknowledge of the pending request |
| req_rdata | output | DATA_W | Read data, valid with `req_ack` for a read |
| st_valid | output | 1 | Storage transaction open; held until `st_ack` |
| st_we | output | 1 | Storage transaction is a write |
| st_addr | output | ADDR_W | Storage word address |
| st_wdata | output | DATA_W | Storage write data |
| st_ack | input | 1 | Storage completes the open transaction (one cycle) |
| st_rdata | input | DATA_W | Storage read data, valid with `st_ack` |
| read_cnt | output | CNT_W | Number of reads accepted |
| hit_cnt | output | CNT_W | Number of reads that hit |

## Verification
The bench uses directed address pairs to tell the cache paths apart. The first pairs are a miss followed by a read of the next address, which separates a working read-ahead from a plain fill. The next is a dirty line sitting exactly where the read-ahead would land, which shows whether that line is protected. After that comes a dirty victim displaced by a read and then by a write, which shows whether the write-back happens before the install. Writes in both acknowledge modes are judged by comparing the storage contents at the moment of acknowledge. A pseudo-random mix of reads and writes over a small address window then exercises conflicts and mode changes, and its read data is compared with a behavioural memory image. A final idle period checks that draining brings storage level with everything the host wrote.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WB,
        S_FILL,
        S_WTHRU,
        S_RA_CHK,
        S_RA,
        S_DRAIN
    } wc_state_e;
endpackage

// File: rtl/wc_line_array.sv
module wc_line_array #(
    parameter int LINES  = 4,
    parameter int LINE_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [LINE_W-1:0] rd_a_line,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [LINE_W-1:0] rd_b_line
);
    logic [LINE_W-1:0] line_q [LINES];
    logic [LINE_W-1:0] line_d [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            line_d[g] = line_q[g];
            if (wr_en && wr_idx == IDX_W'(g)) begin
                line_d[g] = wr_line;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[g] <= '0;
            end else begin
                line_q[g] <= line_d[g];
            end
        end
    end

    assign rd_a_line = line_q[rd_a_idx];
    assign rd_b_line = line_q[rd_b_idx];
endmodule

// File: rtl/wc_stat_counters.sv
module wc_stat_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_inc,
    input  logic             hit_inc,
    output logic [CNT_W-1:0] read_cnt,
    output logic [CNT_W-1:0] hit_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] reads;
        logic [CNT_W-1:0] hits;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        if (rd_inc) begin
            d.reads = q.reads + 1'b1;
        end
        if (hit_inc) begin
            d.hits = q.hits + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign read_cnt = q.reads;
    assign hit_cnt  = q.hits;
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
    import wc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int LINE_W = 2 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_ack_en,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              st_valid,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_wdata,
    input  logic              st_ack,
    input  logic [DATA_W-1:0] st_rdata,
    output logic [IDX_W-1:0]  a_idx,
    input  logic [LINE_W-1:0] a_line,
    output logic [IDX_W-1:0]  b_idx,
    input  logic [LINE_W-1:0] b_line,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [LINE_W-1:0] wr_line,
    output logic              rd_inc,
    output logic              hit_inc
);
    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        wc_state_e         state;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              st_valid;
        logic              st_we;
        logic [ADDR_W-1:0] st_addr;
        logic [DATA_W-1:0] st_wdata;
        logic [ADDR_W-1:0] cur_addr;
        logic              cur_we;
        logic [DATA_W-1:0] cur_wdata;
        logic              cur_early;
        logic [IDX_W-1:0]  drain_ptr;
    } ctrl_t;

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    ctrl_t d, q;
    line_t la, lb, nl;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_match;

    assign sel_addr  = (q.state == S_IDLE) ? req_addr : q.cur_addr;
    assign a_idx     = sel_addr[IDX_W-1:0];
    assign b_idx     = q.drain_ptr;
    assign la        = line_t'(a_line);
    assign lb        = line_t'(b_line);
    assign sel_match = la.valid && (la.tag == tag_of(sel_addr));

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = a_idx;
        nl      = '0;
        rd_inc  = 1'b0;
        hit_inc = 1'b0;

        case (q.state)
            S_IDLE: begin
                if (req_valid) begin
                    d.cur_addr  = req_addr;
                    d.cur_we    = req_we;
                    d.cur_wdata = req_wdata;
                    d.cur_early = early_ack_en;
                    if (!req_we && sel_match) begin
                        rd_inc  = 1'b1;
                        hit_inc = 1'b1;
                        d.ack   = 1'b1;
                        d.rdata = la.data;
                    end else if (!sel_match && la.valid && la.dirty) begin
                        rd_inc     = !req_we;
                        d.st_valid = 1'b1;
                        d.st_we    = 1'b1;
                        d.st_addr  = {la.tag, a_idx};
                        d.st_wdata = la.data;
                        d.state    = S_WB;
                    end else if (!req_we) begin
                        rd_inc     = 1'b1;
                        d.st_valid = 1'b1;
                        d.st_we    = 1'b0;
                        d.st_addr  = req_addr;
                        d.state    = S_FILL;
                    end else begin
                        wr_en = 1'b1;
                        nl    = '{valid: 1'b1, dirty: early_ack_en,
                                  tag: tag_of(req_addr), data: req_wdata};
                        if (early_ack_en) begin
                            d.ack = 1'b1;
                        end else begin
                            d.st_valid = 1'b1;
                            d.st_we    = 1'b1;
                            d.st_addr  = req_addr;
                            d.st_wdata = req_wdata;
                            d.state    = S_WTHRU;
                        end
                    end
                end else if (lb.valid && lb.dirty) begin
                    d.st_valid = 1'b1;
                    d.st_we    = 1'b1;
                    d.st_addr  = {lb.tag, q.drain_ptr};
                    d.st_wdata = lb.data;
                    d.state    = S_DRAIN;
                end else begin
                    d.drain_ptr = q.drain_ptr + 1'b1;
                end
            end

            S_WB: begin
                if (st_ack) begin
                    d.st_valid = 1'b0;
                    if (q.cur_we) begin
                        wr_en = 1'b1;
                        nl    = '{valid: 1'b1, dirty: q.cur_early,
                                  tag: tag_of(q.cur_addr), data: q.cur_wdata};
                        if (q.cur_early) begin
                            d.ack   = 1'b1;
                            d.state = S_IDLE;
                        end else begin
                            d.st_valid = 1'b1;
                            d.st_we    = 1'b1;
                            d.st_addr  = q.cur_addr;
                            d.st_wdata = q.cur_wdata;
                            d.state    = S_WTHRU;
                        end
                    end else begin
                        d.st_valid = 1'b1;
                        d.st_we    = 1'b0;
                        d.st_addr  = q.cur_addr;
                        d.state    = S_FILL;
                    end
                end
            end

            S_FILL: begin
                if (st_ack) begin
                    d.st_valid = 1'b0;
                    wr_en      = 1'b1;
                    nl         = '{valid: 1'b1, dirty: 1'b0,
                                   tag: tag_of(q.cur_addr), data: st_rdata};
                    d.ack      = 1'b1;
                    d.rdata    = st_rdata;
                    d.cur_addr = q.cur_addr + 1'b1;
                    d.state    = S_RA_CHK;
                end
            end

            S_RA_CHK: begin
                if (la.valid && (la.dirty || sel_match)) begin
                    d.state = S_IDLE;
                end else begin
                    d.st_valid = 1'b1;
                    d.st_we    = 1'b0;
                    d.st_addr  = q.cur_addr;
                    d.state    = S_RA;
                end
            end

            S_RA: begin
                if (st_ack) begin
                    d.st_valid = 1'b0;
                    wr_en      = 1'b1;
                    nl         = '{valid: 1'b1, dirty: 1'b0,
                                   tag: tag_of(q.cur_addr), data: st_rdata};
                    d.state    = S_IDLE;
                end
            end

            S_WTHRU: begin
                if (st_ack) begin
                    d.st_valid = 1'b0;
                    d.ack      = 1'b1;
                    d.state    = S_IDLE;
                end
            end

            S_DRAIN: begin
                if (st_ack) begin
                    d.st_valid  = 1'b0;
                    wr_en       = 1'b1;
                    wr_idx      = q.drain_ptr;
                    nl          = lb;
                    nl.dirty    = 1'b0;
                    d.drain_ptr = q.drain_ptr + 1'b1;
                    d.state     = S_IDLE;
                end
            end

            default: d.state = S_IDLE;
        endcase
    end

    assign wr_line = LINE_W'(nl);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ack   = q.ack;
    assign req_rdata = q.rdata;
    assign st_valid  = q.st_valid;
    assign st_we     = q.st_we;
    assign st_addr   = q.st_addr;
    assign st_wdata  = q.st_wdata;
endmodule

// File: rtl/wc_cache.sv
module wc_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_ack_en,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              st_valid,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_wdata,
    input  logic              st_ack,
    input  logic [DATA_W-1:0] st_rdata,
    output logic [CNT_W-1:0]  read_cnt,
    output logic [CNT_W-1:0]  hit_cnt
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int LINE_W = 2 + TAG_W + DATA_W;

    logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
    logic [LINE_W-1:0] a_line, b_line, wr_line;
    logic              wr_en, rd_inc, hit_inc;

    wc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .early_ack_en(early_ack_en),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .st_valid(st_valid), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .st_ack(st_ack), .st_rdata(st_rdata),
        .a_idx(a_idx), .a_line(a_line), .b_idx(b_idx), .b_line(b_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_line(wr_line),
        .rd_inc(rd_inc), .hit_inc(hit_inc)
    );

    wc_line_array #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_line(wr_line), .rd_a_idx(a_idx), .rd_a_line(a_line),
        .rd_b_idx(b_idx), .rd_b_line(b_line)
    );

    wc_stat_counters #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .rd_inc(rd_inc), .hit_inc(hit_inc),
        .read_cnt(read_cnt), .hit_cnt(hit_cnt)
    );
endmodule

// File: rtl/wc_cache_chk.sv
module wc_cache_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ack,
    input logic              st_valid,
    input logic              st_ack,
    input logic              st_we,
    input logic [ADDR_W-1:0] st_addr,
    input logic [CNT_W-1:0]  read_cnt,
    input logic [CNT_W-1:0]  hit_cnt
);
    assert_no_ack_during_storage_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !st_valid);

    assert_storage_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ack) |=> st_valid);

    assert_storage_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ack) |=> ($stable(st_addr) && $stable(st_we)));

    assert_hit_implies_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt != $past(hit_cnt)) |-> (read_cnt != $past(read_cnt)));

    assert_read_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (read_cnt == $past(read_cnt)) || (read_cnt == CNT_W'($past(read_cnt) + 1'b1)));
endmodule

bind wc_cache wc_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .st_valid(st_valid),
    .st_ack(st_ack), .st_we(st_we), .st_addr(st_addr),
    .read_cnt(read_cnt), .hit_cnt(hit_cnt)
);

// File: tb/tb_wc_cache.sv
module tb_wc_cache;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        early_ack_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic        st_valid, st_we;
    logic [7:0]  st_addr;
    logic [15:0] st_wdata;
    logic        st_ack = 1'b0;
    logic [15:0] st_rdata = '0;
    logic [15:0] read_cnt, hit_cnt;

    wc_cache dut (
        .clk(clk), .rst_n(rst_n), .early_ack_en(early_ack_en),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .st_valid(st_valid), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .st_ack(st_ack), .st_rdata(st_rdata),
        .read_cnt(read_cnt), .hit_cnt(hit_cnt)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_srd = 0;
    int n_swr = 0;
    int scnt = 0;
    int exp_reads = 0;
    int exp_hits = 0;
    logic [15:0] stor [256];
    logic [15:0] ref_mem [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // storage model and per-clock protocol comparison
    logic       p_valid = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [7:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_valid && !p_ack)
                chk(st_valid && st_addr == p_addr && st_we == p_we, "R10",
                    "storage request held", int'(st_addr), int'(p_addr));
            chk(!(req_ack && st_valid), "R11", "ack overlaps storage",
                int'(st_valid), 0);
        end
        p_valid = st_valid; p_addr = st_addr; p_we = st_we; p_ack = st_ack;
        if (!rst_n) begin
            st_ack = 1'b0; scnt = 0;
        end else if (st_ack) begin
            st_ack = 1'b0; scnt = 0;
        end else if (st_valid) begin
            scnt++;
            if (scnt >= LAT) begin
                if (st_we) begin
                    stor[st_addr] = st_wdata; n_swr++;
                end else begin
                    st_rdata = stor[st_addr]; n_srd++;
                end
                st_ack = 1'b1;
            end
        end
        p_ack = st_ack;
    end

    task automatic host_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                           input bit early, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        early_ack_en = early; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ack);
        rd = req_rdata;
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp_hit, input bit chk_lat,
                      input string req);
        logic [15:0] d;
        int lat, n0, h0;
        n0 = n_srd; h0 = int'(hit_cnt);
        host_op(1'b0, a, 16'h0, 1'b0, d, lat);
        exp_reads++;
        chk(d == ref_mem[a], req, "read data", int'(d), int'(ref_mem[a]));
        chk(int'(read_cnt) == exp_reads, "R9", "read count", int'(read_cnt), exp_reads);
        if (exp_hit == 1) begin
            exp_hits++;
            chk(n_srd == n0, req, "hit must not read storage", n_srd - n0, 0);
            if (chk_lat) chk(lat == 1, req, "hit latency", lat, 1);
        end else if (exp_hit == 0) begin
            chk(n_srd > n0, req, "miss must read storage", n_srd - n0, 1);
        end else begin
            exp_hits += int'(hit_cnt) - h0;
        end
        chk(int'(hit_cnt) == exp_hits, "R9", "hit count", int'(hit_cnt), exp_hits);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v, input bit early,
                      output int lat);
        logic [15:0] d;
        host_op(1'b1, a, v, early, d, lat);
        ref_mem[a] = v;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int lat, n0, w0, mism;
        logic [15:0] old;
        logic [7:0] lfsr;
        for (int i = 0; i < 256; i++) begin
            stor[i] = 16'(i) * 16'h0101 ^ 16'h5A00;
            ref_mem[i] = stor[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!req_ack, "R12", "ack after reset", int'(req_ack), 0);
        chk(!st_valid, "R12", "storage idle after reset", int'(st_valid), 0);
        chk(read_cnt == 0 && hit_cnt == 0, "R12", "counters after reset",
            int'(read_cnt) + int'(hit_cnt), 0);

        // R2/R12: first read misses; R3: read-ahead of next address
        n0 = n_srd;
        rd(8'h10, 0, 1'b0, "R2");
        repeat (10) @(negedge clk);
        chk(n_srd == n0 + 2, "R3", "read-ahead fetch count", n_srd - n0, 2);
        rd(8'h11, 1, 1'b1, "R3");
        rd(8'h10, 1, 1'b1, "R1");

        // R5: early acknowledge, storage not yet written; R8: drained later
        old = stor[8'h12];
        wr(8'h12, 16'hAAAA, 1'b1, lat);
        chk(lat == 1, "R5", "early write latency", lat, 1);
        chk(stor[8'h12] == old, "R5", "storage still old at ack", int'(stor[8'h12]), int'(old));
        repeat (30) @(negedge clk);
        chk(stor[8'h12] == 16'hAAAA, "R8", "drained word", int'(stor[8'h12]), 16'hAAAA);
        rd(8'h12, 1, 1'b1, "R1");

        // R6: write-through acknowledge
        wr(8'h13, 16'h5555, 1'b0, lat);
        chk(stor[8'h13] == 16'h5555, "R6", "storage at ack", int'(stor[8'h13]), 16'h5555);
        chk(lat > LAT, "R6", "write-through latency", lat, LAT + 1);

        // R4: read-ahead target holds a dirty line
        wr(8'h25, 16'hBEEF, 1'b1, lat);
        n0 = n_srd;
        rd(8'h24, 0, 1'b0, "R2");
        repeat (12) @(negedge clk);
        chk(n_srd == n0 + 1, "R4", "read-ahead skipped", n_srd - n0, 1);
        rd(8'h25, 1, 1'b0, "R4");
        rd(8'h21, 0, 1'b0, "R4");

        // R7: dirty victim written back before a read replaces it
        repeat (20) @(negedge clk);
        w0 = n_swr;
        wr(8'h06, 16'h1234, 1'b1, lat);
        rd(8'h0A, 0, 1'b0, "R7");
        chk(stor[8'h06] == 16'h1234, "R7", "victim written back", int'(stor[8'h06]), 16'h1234);
        chk(n_swr == w0 + 1, "R7", "one write-back", n_swr - w0, 1);
        rd(8'h06, 0, 1'b0, "R7");

        // R7 + R6: dirty victim replaced by a write-through write
        wr(8'h30, 16'h7777, 1'b1, lat);
        wr(8'h34, 16'h8888, 1'b0, lat);
        chk(stor[8'h30] == 16'h7777, "R7", "victim before write", int'(stor[8'h30]), 16'h7777);
        chk(stor[8'h34] == 16'h8888, "R6", "write-through data", int'(stor[8'h34]), 16'h8888);
        rd(8'h34, 1, 1'b0, "R1");

        // mixed traffic
        lfsr = 8'hA5;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[6])
                wr({3'b000, lfsr[4:0]}, 16'(k) * 16'h0313 + 16'h0101, lfsr[7], lat);
            else
                rd({3'b000, lfsr[4:0]}, -1, 1'b0, "R2");
        end
        chk(hit_cnt <= read_cnt, "R9", "hits within reads", int'(hit_cnt), int'(read_cnt));

        // R8: everything drained while idle
        repeat (100) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 256; i++)
            if (stor[i] != ref_mem[i]) mism++;
        chk(mism == 0, "R8", "storage matches host image", mism, 0);
        finish_run();
    end
endmodule